// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Register

This block generates the row-select pattern for a display panel. A start bit is presented on one of two shared data pins and is captured on a rising clock edge. Each further rising edge moves every bit one row along the chain. A static direction level picks the direction. It also picks which data pin acts as the input and which one passes the bit on to a cascaded next device.

A static length level can shorten the chain. In short mode a fixed group of middle rows is cut out of the shift path, and those rows are held at the inactive level. A blanking input forces every row output low at once, without waiting for a clock, while the chain keeps shifting underneath. The cascade bit is the content of the final row in the current direction. It is re-timed on the falling clock edge, so a following device can capture it safely on its next rising edge.

Each row output is a logic-level select: 1 selects the high gate rail and 0 the low rail. Each data pin comes with a separate input, a separate output and an output enable, so the pads can be built outside this block.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst` is high on a rising edge, every row is cleared. While `rst` is high on a falling edge, the cascade bit is cleared.
- R2: When `dir_up` is 1, the bit on `pin_a_in` is captured into row index 0 (line 1) on each rising edge, and `pin_b_in` has no effect.
- R3: When `dir_up` is 0, the bit on `pin_b_in` is captured into row index N_LINES-1 (the last line) on each rising edge, and `pin_a_in` has no effect.
- R4: On each rising edge, every row takes the content of its neighbour one step back along the direction: index i-1 when `dir_up` is 1, and index i+1 when it is 0.
- R5: When `full_mode` is 0, rows BYP_LO to BYP_LO+BYP_COUNT-1 (0-based, default 170..177) are skipped. Going up, index BYP_LO-1 feeds index BYP_LO+BYP_COUNT. Going down, the feed runs the other way.
- R6: When `full_mode` is 0, the skipped rows read 0 at all times.
- R7: While `blank` is 1, all of `rows` is 0, with no clock edge needed. Shifting carries on underneath, and when `blank` returns to 0 each row shows its register content.
- R8: The cascade bit is updated on the falling edge to the content of the last active row (index N_LINES-1 going up, index 0 going down). It is driven on `pin_b_out` when `dir_up` is 1 and on `pin_a_out` when `dir_up` is 0. A single start bit captured at clock 1 is therefore present for capture by the next device at clock L+1: clock 351 with the full chain and clock 343 with the short chain.
- R9: Exactly one pin output enable is high: `pin_b_oe` when `dir_up` is 1, and `pin_a_oe` when `dir_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Static direction: 1 = towards the last line, 0 = towards line 1 |
| full_mode | input | 1 | Static length: 1 = all rows, 0 = middle group bypassed |
| blank | input | 1 | Asynchronous blanking, 1 = all rows inactive |
| pin_a_in | input | 1 | Data pin A, input side |
| pin_b_in | input | 1 | Data pin B, input side |
| pin_a_out | output | 1 | Data pin A, output side (cascade bit) |
| pin_b_out | output | 1 | Data pin B, output side (cascade bit) |
| pin_a_oe | output | 1 | Output enable for pin A |
| pin_b_oe | output | 1 | Output enable for pin B |
| rows | output | N_LINES | Row select outputs, bit i = line i+1 |

## Verification
Two functions can fall in the same cycle: blanking and shifting. While `blank` is high, a pulse train is still moving through the chain, crossing the bypass join in short mode and reaching the cascade stage. The bench raises and drops `blank` between clock edges and checks the rows a fraction of a nanosecond later: all zero while blanked, then the exact positions the queue model predicts once released. A second overlap is a new start bit being captured on the same edge that an earlier bit moves into the cascade register. A multi-pulse pattern provokes it, and on every cycle both the row vector and the cascade pin are compared against the model.

// File: rtl/rss_pkg.sv
`timescale 1ns/1ps
package rss_pkg;
  typedef enum logic {
    SCAN_DOWN = 1'b0,
    SCAN_UP   = 1'b1
  } scan_dir_e;

  function automatic bit in_bypass(input int idx, input int lo, input int cnt);
    return (idx >= lo) && (idx < lo + cnt);
  endfunction
endpackage

// File: rtl/rss_chain.sv
`timescale 1ns/1ps
module rss_chain #(
  parameter int N_LINES   = 350,
  parameter int BYP_LO    = 170,
  parameter int BYP_COUNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  rss_pkg::scan_dir_e dir,
  input  logic               full_mode,
  input  logic               din_up,
  input  logic               din_dn,
  output logic [N_LINES-1:0] stg
);
  localparam int BYP_HI = BYP_LO + BYP_COUNT - 1;

  for (genvar i = 0; i < N_LINES; i++) begin : g_stage
    logic up_src;
    logic dn_src;

    if (i == 0) begin : g_up_first
      assign up_src = din_up;
    end else if (i == BYP_HI + 1) begin : g_up_join
      assign up_src = full_mode ? stg[i-1] : stg[BYP_LO-1];
    end else begin : g_up_plain
      assign up_src = stg[i-1];
    end

    if (i == N_LINES - 1) begin : g_dn_first
      assign dn_src = din_dn;
    end else if (i == BYP_LO - 1) begin : g_dn_join
      assign dn_src = full_mode ? stg[i+1] : stg[BYP_HI+1];
    end else begin : g_dn_plain
      assign dn_src = stg[i+1];
    end

    if (rss_pkg::in_bypass(i, BYP_LO, BYP_COUNT)) begin : g_byp
      always_ff @(posedge clk) begin
        if (rst || !full_mode) stg[i] <= 1'b0;
        else                   stg[i] <= (dir == rss_pkg::SCAN_UP) ? up_src : dn_src;
      end
    end else begin : g_act
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= (dir == rss_pkg::SCAN_UP) ? up_src : dn_src;
      end
    end
  end
endmodule

// File: rtl/rss_carry.sv
`timescale 1ns/1ps
module rss_carry #(
  parameter int N_LINES = 350
) (
  input  logic               clk,
  input  logic               rst,
  input  rss_pkg::scan_dir_e dir,
  input  logic [N_LINES-1:0] stg,
  output logic               carry
);
  logic last_bit;
  assign last_bit = (dir == rss_pkg::SCAN_UP) ? stg[N_LINES-1] : stg[0];

  always_ff @(negedge clk) begin
    if (rst) carry <= 1'b0;
    else     carry <= last_bit;
  end
endmodule

// File: rtl/rss_outgate.sv
`timescale 1ns/1ps
module rss_outgate #(
  parameter int N_LINES   = 350,
  parameter int BYP_LO    = 170,
  parameter int BYP_COUNT = 8
) (
  input  logic               blank,
  input  logic               full_mode,
  input  logic [N_LINES-1:0] stg,
  output logic [N_LINES-1:0] rows
);
  logic [N_LINES-1:0] keep;

  for (genvar i = 0; i < N_LINES; i++) begin : g_mask
    if (rss_pkg::in_bypass(i, BYP_LO, BYP_COUNT)) begin : g_b
      assign keep[i] = full_mode;
    end else begin : g_k
      assign keep[i] = 1'b1;
    end
  end

  assign rows = blank ? '0 : (stg & keep);
endmodule

// File: rtl/row_scan_shifter.sv
`timescale 1ns/1ps
module row_scan_shifter #(
  parameter int N_LINES   = 350,
  parameter int BYP_LO    = 170,
  parameter int BYP_COUNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dir_up,
  input  logic               full_mode,
  input  logic               blank,
  input  logic               pin_a_in,
  input  logic               pin_b_in,
  output logic               pin_a_out,
  output logic               pin_b_out,
  output logic               pin_a_oe,
  output logic               pin_b_oe,
  output logic [N_LINES-1:0] rows
);
  rss_pkg::scan_dir_e dir;
  logic [N_LINES-1:0] stg;
  logic               carry;

  assign dir = dir_up ? rss_pkg::SCAN_UP : rss_pkg::SCAN_DOWN;

  rss_chain #(.N_LINES(N_LINES), .BYP_LO(BYP_LO), .BYP_COUNT(BYP_COUNT)) u_chain (
    .clk(clk), .rst(rst), .dir(dir), .full_mode(full_mode),
    .din_up(pin_a_in), .din_dn(pin_b_in), .stg(stg)
  );

  rss_carry #(.N_LINES(N_LINES)) u_carry (
    .clk(clk), .rst(rst), .dir(dir), .stg(stg), .carry(carry)
  );

  rss_outgate #(.N_LINES(N_LINES), .BYP_LO(BYP_LO), .BYP_COUNT(BYP_COUNT)) u_gate (
    .blank(blank), .full_mode(full_mode), .stg(stg), .rows(rows)
  );

  assign pin_a_oe  = (dir == rss_pkg::SCAN_DOWN);
  assign pin_b_oe  = (dir == rss_pkg::SCAN_UP);
  assign pin_a_out = carry;
  assign pin_b_out = carry;
endmodule

// File: rtl/row_scan_shifter_chk.sv
`timescale 1ns/1ps
module row_scan_shifter_chk #(
  parameter int N_LINES   = 350,
  parameter int BYP_LO    = 170,
  parameter int BYP_COUNT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               dir_up,
  input logic               full_mode,
  input logic               blank,
  input logic               pin_a_in,
  input logic               pin_b_in,
  input logic               pin_a_out,
  input logic               pin_b_out,
  input logic               pin_a_oe,
  input logic               pin_b_oe,
  input logic [N_LINES-1:0] rows,
  input logic [N_LINES-1:0] stg
);
  localparam int BYP_HI = BYP_LO + BYP_COUNT - 1;

  // R1
  reset_clears_chk: assert property (@(posedge clk) $past(rst) |-> (stg == '0));

  // R2
  up_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_up && !blank) |=> (blank || rows[0] == $past(pin_a_in)));

  // R3
  down_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && !blank) |=> (blank || rows[N_LINES-1] == $past(pin_b_in)));

  // R4
  up_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_up && !blank) |=> (blank || rows[1] == $past(rows[0])));

  // R4
  down_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && !blank) |=> (blank || rows[N_LINES-2] == $past(rows[N_LINES-1])));

  // R5
  up_join_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_up && !full_mode && !blank) |=> (blank || rows[BYP_HI+1] == $past(rows[BYP_LO-1])));

  // R5
  down_join_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && !full_mode && !blank) |=> (blank || rows[BYP_LO-1] == $past(rows[BYP_HI+1])));

  // R6
  bypass_low_chk: assert property (@(posedge clk) disable iff (rst)
    !full_mode |-> (rows[BYP_HI:BYP_LO] == '0));

  // R7
  blank_low_chk: assert property (@(posedge clk) disable iff (rst)
    blank |-> (rows == '0));

  // R8
  carry_up_chk: assert property (@(posedge clk) disable iff (rst)
    dir_up |-> (pin_b_out == stg[N_LINES-1]));

  // R8
  carry_down_chk: assert property (@(posedge clk) disable iff (rst)
    !dir_up |-> (pin_a_out == stg[0]));

  // R9
  one_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({pin_a_oe, pin_b_oe}) && (pin_b_oe == dir_up));
endmodule

bind row_scan_shifter row_scan_shifter_chk #(
  .N_LINES(N_LINES), .BYP_LO(BYP_LO), .BYP_COUNT(BYP_COUNT)
) u_chk (
  .clk(clk), .rst(rst), .dir_up(dir_up), .full_mode(full_mode), .blank(blank),
  .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .pin_a_out(pin_a_out),
  .pin_b_out(pin_b_out), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
  .rows(rows), .stg(stg)
);

// File: tb/row_scan_shifter_test.sv
`timescale 1ns/1ps
module row_scan_shifter_test;
  localparam int N = 350;
  localparam int BLO = 170;
  localparam int BCNT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_up = 1'b1;
  logic full_mode = 1'b1;
  logic blank = 1'b0;
  logic pin_a_in = 1'b0;
  logic pin_b_in = 1'b0;
  logic pin_a_out, pin_b_out, pin_a_oe, pin_b_oe;
  logic [N-1:0] rows;

  int n_cmp = 0;
  int n_bad = 0;
  bit mdl[N];
  bit mcarry;
  int path[$];

  always #2.5 clk = ~clk;

  row_scan_shifter #(.N_LINES(N), .BYP_LO(BLO), .BYP_COUNT(BCNT)) uut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .full_mode(full_mode), .blank(blank),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .pin_a_out(pin_a_out),
    .pin_b_out(pin_b_out), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe), .rows(rows)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_path();
    path.delete();
    for (int k = 0; k < N; k++) begin
      int idx = dir_up ? k : N - 1 - k;
      if (full_mode || idx < BLO || idx >= BLO + BCNT) path.push_back(idx);
    end
  endtask

  task automatic compare(input string req);
    int bad_line = -1;
    logic exp_bit;
    for (int i = 0; i < N; i++) begin
      exp_bit = blank ? 1'b0 : mdl[i];
      if (bad_line < 0 && rows[i] !== exp_bit) bad_line = i;
    end
    check(bad_line < 0, req, "row mismatch at index", bad_line, -1);
    check((dir_up ? pin_b_out : pin_a_out) === mcarry, "R8", "cascade bit",
          dir_up ? pin_b_out : pin_a_out, mcarry);
    check(pin_a_oe === !dir_up && pin_b_oe === dir_up, "R9", "enables {a,b}",
          {pin_a_oe, pin_b_oe}, {!dir_up, dir_up});
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    if (rst) begin
      foreach (mdl[i]) mdl[i] = 1'b0;
    end else begin
      for (int j = path.size() - 1; j > 0; j--) mdl[path[j]] = mdl[path[j-1]];
      mdl[path[0]] = dir_up ? pin_a_in : pin_b_in;
    end
    @(negedge clk);
    mcarry = rst ? 1'b0 : mdl[path[path.size()-1]];
    #1;
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pin_a_in = 1'b0;
    pin_b_in = 1'b0;
    blank = 1'b0;
    build_path();
    repeat (3) tick("R1");
    check(rows == '0, "R1", "rows after reset", rows != '0, 0);
    check(pin_a_out == 1'b0 && pin_b_out == 1'b0, "R1", "cascade after reset",
          pin_a_out | pin_b_out, 0);
    rst = 1'b0;
  endtask

  task automatic run(input bit up, input bit full, input bit multi, input string req);
    int first = -1;
    int len;
    dir_up = up;
    full_mode = full;
    do_reset();
    len = path.size();
    for (int k = 1; k <= len + 12; k++) begin
      bit d = multi ? (k == 1 || k == 3 || k == 4 || k == 6) : (k == 1);
      if (up) begin pin_a_in = d; pin_b_in = 1'($urandom); end
      else    begin pin_b_in = d; pin_a_in = 1'($urandom); end
      blank = (k >= 100 && k < 104) || (k >= len - 2 && k < len + 1);
      tick(req);
      if (first < 0 && (up ? pin_b_out : pin_a_out)) first = k;
    end
    // cascade bit readable by the next device at clock len+1
    check(first == len, "R8", "edge after which cascade rises", first, len);
    blank = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    run(1'b1, 1'b1, 1'b0, "R2 R4 R7");
    run(1'b0, 1'b1, 1'b0, "R3 R4 R7");
    run(1'b1, 1'b0, 1'b1, "R2 R5 R6 R7");
    run(1'b0, 1'b0, 1'b1, "R3 R5 R6 R7");

    // R7: asynchronous blanking and release within one clock phase
    dir_up = 1'b1; full_mode = 1'b1;
    do_reset();
    pin_a_in = 1'b1; tick("R2");
    pin_a_in = 1'b0;
    repeat (20) tick("R4");
    blank = 1'b1; #0.3;
    check(rows == '0, "R7", "rows while blanked mid-cycle", rows != '0, 0);
    blank = 1'b0; #0.3;
    check(rows[20] == 1'b1, "R7", "row 20 after release", rows[20], 1);
    tick("R4");
    // R1: reset in the middle of a scan
    rst = 1'b1; tick("R1"); tick("R1");
    check(rows == '0, "R1", "rows after mid-scan reset", rows != '0, 0);
    check(pin_b_out == 1'b0, "R1", "cascade after mid-scan reset", pin_b_out, 0);
    rst = 1'b0;
    repeat (5) tick("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule